// File: doc/BRIEF.md
# Three-Input Maskable Interrupt Front End with Cascade

This block sits between three external, asynchronous interrupt request pins and a processor core. Each pin is brought into the clock domain through a two-stage synchronizer. Each input is then treated as level-sensitive or as rising-edge latched, according to its own configuration bit, and gated by its own mask bit. Surviving requests go to a fixed-priority selector. The selector raises a single request line to the core. When the core acknowledges, the block returns a one-cycle vector-valid pulse together with the vector index.

Input 0 has two alternative service modes. In cascade mode the pin of input 2 stops acting as a request. It becomes an active-low acknowledge output, held low for a fixed window. At the end of that window the block takes the interrupt type from the data bus instead of using its own index. In slave mode, an acknowledged input-0 request waits for an active-low select input. The type is taken from the data bus when that select input goes low. A small write/read port holds the mask, trigger and mode settings.

Top module: `irq_front3`

## Requirements
- R1: Every request pin passes through two flip-flop stages. A level-mode request raises `irq` two clock edges after the pin changes, and an edge-mode request raises it three edges after.
- R2: For an edge-mode input (its `trig` bit = 1), a rising edge sets a pending bit. That bit survives the pin falling again and is cleared only when that input is acknowledged. A pin held high afterwards does not request again.
- R3: A masked input (its `mask` bit = 1) never raises `irq`. The mask resets to all ones.
- R4: A level-mode request that drops before acknowledge is withdrawn. `irq` falls, and a later `irq_ack` produces no `vec_vld`.
- R5: Priority is fixed: input 0 first, then input 1, then input 2. In normal service the vector index equals the input number.
- R6: An `irq_ack` while `irq` is high gives exactly one `vec_vld` cycle, and for normal service that cycle is the next one. While `irq` is low, `irq_ack` is ignored.
- R7: In cascade mode (mode bit 0 = 1), `pin2_oe` is high and pin 2 is ignored as a request. Acknowledging input 0 drives `cas_ack_n` low for ACK_CYC cycles, and `irq` stays low throughout that window.
- R8: In cascade mode the vector is the `bus_data` value present in the last low cycle of `cas_ack_n`. `vec_vld` is high in the first cycle after `cas_ack_n` returns high.
- R9: In slave mode (mode = 2'b10), an acknowledged input-0 request waits with no `vec_vld` until `sel_n` is low. `bus_data` is captured at that edge and `vec_vld` follows one cycle later. `sel_n` has no effect while no such request is waiting.
- R10: Register port: address 0 holds the mask [2:0], address 1 the trigger select [2:0] (1 = edge), and address 2 the mode [1:0] (bit 0 cascade, bit 1 slave; cascade takes precedence when both bits are set). Address 3 reads zero. Trigger and mode reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_in | input | 3 | Asynchronous request pins; bit 2 is unused in cascade mode |
| sel_n | input | 1 | Active-low slave select: type is on the bus |
| bus_data | input | VW | Data bus carrying an external interrupt type |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address |
| cfg_wdata | input | 3 | Configuration write data |
| cfg_rdata | output | 3 | Configuration read data |
| irq_ack | input | 1 | Core acknowledge, one cycle |
| irq | output | 1 | Request to the core |
| vec_vld | output | 1 | Vector valid pulse |
| vec | output | VW | Vector index or captured type |
| cas_ack_n | output | 1 | Active-low cascade acknowledge driven onto pin 2 |
| pin2_oe | output | 1 | Pin 2 acts as an output (cascade mode) |

## Verification
The pin patterns used are:
- a single level request, with its exact latency counted;
- a single edge pulse, with its exact latency counted;
- an edge input held high after service;
- a masked request that is unmasked later;
- a level request withdrawn before acknowledge;
- all three inputs raised at once and then released one by one.

Together these separate a level path from an edge path, a missing or extra synchronizer stage, a pending bit that fails to clear, and a wrong priority order. In cascade mode, pin 2 is raised alongside input 0 while the data bus changes right after the window closes, which shows whether the type is taken at the trailing cycle. In slave mode, select is held off and then pulsed, and it is also pulsed with no request waiting, which shows that the capture is tied to the acknowledged request.

// File: rtl/irq_front3.sv
module irq_front3 #(
  parameter int VW      = 8,
  parameter int ACK_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    req_in,
  input  logic          sel_n,
  input  logic [VW-1:0] bus_data,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [2:0]    cfg_wdata,
  output logic [2:0]    cfg_rdata,
  input  logic          irq_ack,
  output logic          irq,
  output logic          vec_vld,
  output logic [VW-1:0] vec,
  output logic          cas_ack_n,
  output logic          pin2_oe
);
  localparam int CW = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;

  typedef enum logic [1:0] {IDLE, CASW, SLVW} st_t;

  st_t         st;
  logic [2:0]  s1, s2, s3, pend, mask, trig;
  logic [1:0]  mode;
  logic [CW-1:0] cnt;
  logic [2:0]  active, usable, clr;
  logic [1:0]  win;
  logic        cas, slv, take;

  assign cas     = mode[0];
  assign slv     = mode[1] & ~mode[0];
  assign pin2_oe = cas;
  assign active  = (trig & pend) | (~trig & s2);
  assign usable  = active & ~mask & {~cas, 2'b11};
  assign irq     = (st == IDLE) & (|usable);
  assign take    = irq & irq_ack;
  assign win     = usable[0] ? 2'd0 : (usable[1] ? 2'd1 : 2'd2);
  assign clr     = take ? (3'b001 << win) : 3'b000;
  assign cas_ack_n = (st != CASW);

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = mask;
      2'd1:    cfg_rdata = trig;
      2'd2:    cfg_rdata = {1'b0, mode};
      default: cfg_rdata = 3'b000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; pend <= '0;
      mask <= 3'b111; trig <= '0; mode <= '0;
    end else begin
      s1   <= req_in;
      s2   <= s1;
      s3   <= s2;
      pend <= (pend | (s2 & ~s3)) & ~clr;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0:    mask <= cfg_wdata;
          2'd1:    trig <= cfg_wdata;
          2'd2:    mode <= cfg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; vec_vld <= 1'b0; vec <= '0;
    end else begin
      vec_vld <= 1'b0;
      case (st)
        IDLE: if (take) begin
          if (win == 2'd0 && cas) begin
            st  <= CASW;
            cnt <= CW'(ACK_CYC - 1);
          end else if (win == 2'd0 && slv) begin
            st <= SLVW;
          end else begin
            vec     <= VW'(win);
            vec_vld <= 1'b1;
          end
        end
        CASW: if (cnt == '0) begin
          vec     <= bus_data;
          vec_vld <= 1'b1;
          st      <= IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        SLVW: if (!sel_n) begin
          vec     <= bus_data;
          vec_vld <= 1'b1;
          st      <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_mask_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b111) |-> !irq);
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |=> !vec_vld);
  assert_ack_in_cascade_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_ack_n |-> pin2_oe);
  assert_no_irq_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_ack_n |-> !irq);
  assert_trailing_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_ack_n) |-> vec_vld);
  assert_slave_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLVW && sel_n) |=> !vec_vld);
endmodule

// File: tb/sim_irq_front3.sv
module sim_irq_front3;
  localparam int VW = 8;
  localparam int AC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] req_in = '0;
  logic sel_n = 1'b1;
  logic [VW-1:0] bus_data = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [2:0] cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic irq_ack = 1'b0;
  logic irq, vec_vld, cas_ack_n, pin2_oe;
  logic [VW-1:0] vec;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_front3 #(.VW(VW), .ACK_CYC(AC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .sel_n(sel_n), .bus_data(bus_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_ack(irq_ack), .irq(irq), .vec_vld(vec_vld), .vec(vec),
    .cas_ack_n(cas_ack_n), .pin2_oe(pin2_oe));

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string tag);
    cfg_addr = a;
    #1;
    chk(int'(cfg_rdata), exp, tag);
  endtask

  task automatic ack;
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
  endtask

  task automatic setup(input logic [2:0] m, input logic [2:0] t, input logic [2:0] md);
    wr(2'd0, m); wr(2'd1, t); wr(2'd2, md);
  endtask

  task automatic t_reset;
    chk(irq, 0, "R6 reset irq");
    chk(vec_vld, 0, "R6 reset vec_vld");
    chk(cas_ack_n, 1, "R7 reset cas_ack_n");
    rd(2'd0, 7, "R10 reset mask");
    rd(2'd1, 0, "R10 reset trig");
    rd(2'd2, 0, "R10 reset mode");
  endtask

  task automatic t_regs;
    wr(2'd0, 3'd5); rd(2'd0, 5, "R10 mask rw");
    wr(2'd1, 3'd6); rd(2'd1, 6, "R10 trig rw");
    wr(2'd2, 3'd3); rd(2'd2, 3, "R10 mode rw");
    chk(pin2_oe, 1, "R10 cascade precedence");
    wr(2'd3, 3'd7); rd(2'd3, 0, "R10 addr3 zero");
    setup(3'd7, 3'd0, 3'd0);
  endtask

  task automatic t_mask;
    req_in[1] = 1'b1;
    cyc(4);
    chk(irq, 0, "R3 all masked");
    wr(2'd0, 3'b010);
    cyc(2);
    chk(irq, 0, "R3 input1 masked");
    wr(2'd0, 3'b000);
    chk(irq, 1, "R3 unmasked");
    ack;
    chk(vec_vld, 1, "R6 vld after ack");
    chk(int'(vec), 1, "R5 vec input1");
    cyc(1);
    chk(vec_vld, 0, "R6 single pulse");
    req_in[1] = 1'b0;
    cyc(3);
  endtask

  task automatic t_level_sync;
    setup(3'd0, 3'd0, 3'd0);
    req_in[1] = 1'b1;
    cyc(1); chk(irq, 0, "R1 level one edge");
    cyc(1); chk(irq, 1, "R1 level two edges");
    req_in[1] = 1'b0;
    cyc(1); chk(irq, 1, "R1 level fall one edge");
    cyc(1); chk(irq, 0, "R4 level withdrawn");
    ack;
    chk(vec_vld, 0, "R4 ack after withdraw");
    cyc(1);
    chk(vec_vld, 0, "R6 ack ignored when idle");
  endtask

  task automatic t_edge;
    setup(3'd0, 3'b001, 3'd0);
    req_in[0] = 1'b1;
    cyc(2); chk(irq, 0, "R1 edge two edges");
    cyc(1); chk(irq, 1, "R1 edge three edges");
    req_in[0] = 1'b0;
    cyc(4); chk(irq, 1, "R2 pending held");
    ack;
    chk(int'(vec), 0, "R5 vec input0");
    chk(irq, 0, "R2 pending cleared");
    req_in[0] = 1'b1;
    cyc(4); chk(irq, 1, "R2 second edge");
    ack;
    cyc(4); chk(irq, 0, "R2 held high no rerequest");
    req_in[0] = 1'b0;
    cyc(3);
  endtask

  task automatic t_priority;
    setup(3'd0, 3'd0, 3'd0);
    req_in = 3'b111;
    cyc(3);
    ack; chk(int'(vec), 0, "R5 all three -> 0");
    req_in[0] = 1'b0; cyc(3);
    ack; chk(int'(vec), 1, "R5 inputs 1,2 -> 1");
    req_in[1] = 1'b0; cyc(3);
    ack; chk(int'(vec), 2, "R5 input 2 alone");
    req_in = 3'b000; cyc(3);
  endtask

  task automatic t_cascade;
    setup(3'd0, 3'd0, 3'd1);
    chk(pin2_oe, 1, "R7 pin2 output");
    req_in[2] = 1'b1;
    cyc(4); chk(irq, 0, "R7 pin2 request ignored");
    req_in[0] = 1'b1;
    bus_data = 8'hA5;
    cyc(3); chk(irq, 1, "R7 input0 request");
    ack;
    for (int k = 0; k < AC; k++) begin
      chk(cas_ack_n, 0, "R7 ack window low");
      chk(irq, 0, "R7 irq low in window");
      chk(vec_vld, 0, "R8 no vld in window");
      if (k == AC - 1) bus_data = 8'hA5;
      cyc(1);
      if (k == AC - 1) bus_data = 8'h5A;
    end
    chk(cas_ack_n, 1, "R7 window ends");
    chk(vec_vld, 1, "R8 vld after window");
    chk(int'(vec), 8'hA5, "R8 bus type captured");
    req_in = 3'b000;
    wr(2'd2, 3'd0);
    cyc(3);
  endtask

  task automatic t_slave;
    setup(3'd0, 3'd0, 3'd2);
    chk(pin2_oe, 0, "R9 pin2 stays input");
    req_in[0] = 1'b1;
    bus_data = 8'h3C;
    cyc(3);
    ack;
    chk(vec_vld, 0, "R9 waits for select");
    cyc(3);
    chk(vec_vld, 0, "R9 still waiting");
    sel_n = 1'b0;
    cyc(1);
    sel_n = 1'b1;
    bus_data = 8'h00;
    chk(vec_vld, 1, "R9 vld after select");
    chk(int'(vec), 8'h3C, "R9 bus type captured");
    req_in[0] = 1'b0;
    cyc(3);
    sel_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      chk(vec_vld, 0, "R9 select ignored when idle");
    end
    sel_n = 1'b1;
    wr(2'd2, 3'd0);
  endtask

  initial begin
    #(8 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_regs;
    t_mask;
    t_level_sync;
    t_edge;
    t_priority;
    t_cascade;
    t_slave;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule